// File: doc/BRIEF.md
# Boot Alias Address Decoder

This block sits at the front of a bus matrix slave region and turns each access address into a one-hot target select and an offset within the target. Every memory stays reachable at its own fixed base. The lowest 1 MB of the map is also a boot alias window, and it reaches one of three targets.

Which target the alias window reaches depends on two pieces of state. The first is a boot mode strap, which is captured while reset is held and is then frozen. Before any remap, a strap of 1 sends the window to the internal ROM and a strap of 0 sends it to the external chip select 0 region. The second is a remap flag, which software sets with a control write. Once the flag is set, the window goes to the remap SRAM bank whatever the strap holds. The flag stays set until the next reset.

Selects, offset and decode error are combinational from the access inputs. The strap and the remap flag are the only state.

Top module: `bootmap_decoder`

## Requirements
- R1: The boot mode pin is captured on every clock edge while reset is high. The captured value then holds until the next reset, so changes on the pin after reset have no effect on the alias routing.
- R2: With a captured strap of 1 and no remap, a valid access in the window 0x0000_0000 to 0x000F_FFFF asserts only tgt_sel bit 0 (internal ROM).
- R3: With a captured strap of 0 and no remap, a valid access in the alias window asserts only tgt_sel bit 1 (external chip select 0).
- R4: A cfg_wr cycle with cfg_wdata = 1 sets the remap flag at that clock edge. From the next cycle on, a valid access in the alias window asserts only tgt_sel bit 2 (remap SRAM bank), whatever the strap holds. During the write cycle itself the window keeps its previous routing.
- R5: The remap flag is cleared by reset only. A cfg_wr with cfg_wdata = 0 changes nothing, and the flag is clear after every reset.
- R6: Fixed bases are reachable whatever the strap and remap state. Each base spans 1 MB. The bases and their tgt_sel bits are: ROM at 0x0040_0000 on bit 0, external chip select 0 at 0x1000_0000 on bit 1, remap bank at 0x0030_0000 on bit 2, SRAM bank A at 0x0010_0000 on bit 3, SRAM bank B at 0x0020_0000 on bit 4.
- R7: tgt_offset equals the low 20 address bits. An aliased target therefore sees the same offset as when it is reached at its own base.
- R8: A valid access that matches no region raises dec_err in that cycle and asserts no tgt_sel bit.
- R9: With acc_valid low, tgt_sel is all zero and dec_err is low.
- R10: At most one tgt_sel bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the strap capture window |
| boot_mode_pin | input | 1 | Boot mode strap input |
| cfg_wr | input | 1 | Write strobe for the remap control word |
| cfg_wdata | input | 1 | Bit 0 of the remap control word; 1 requests the remap |
| acc_valid | input | 1 | Access address is valid |
| acc_addr | input | 32 | Access byte address |
| tgt_sel | output | 5 | One-hot target select (bit order given in R6) |
| tgt_offset | output | 20 | Offset within the selected 1 MB target |
| dec_err | output | 1 | Valid access matched no region |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 1 MB window (20 offset bits) and the five default bases. With these values every region boundary, including the top of the alias window and the first address past the ROM, is a literal address the vector table can hit. The same settings let the bench set each strap value, change the pin after reset, and order remap writes around accesses, so both alias routings, the remap takeover and its persistence across zero writes can all be checked.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    localparam int NUM_TGT = 5;

    // Target indices; the index is the bit position in the select vector.
    typedef enum logic [2:0] {
        TGT_ROM   = 3'd0,
        TGT_EXT   = 3'd1,
        TGT_BANKC = 3'd2,
        TGT_BANKA = 3'd3,
        TGT_BANKB = 3'd4
    } tgt_e;

    // Routing of the window at address zero.
    function automatic tgt_e alias_route(input logic strap, input logic remapped);
        if (remapped) return TGT_BANKC;
        else if (strap) return TGT_ROM;
        else return TGT_EXT;
    endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic strap_q
);
    // Tracks the pin while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) strap_q <= pin;
    end
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wbit,
    output logic remap_q
);
    // Sticky: only reset clears it.
    always_ff @(posedge clk) begin
        if (rst)             remap_q <= 1'b0;
        else if (wr && wbit) remap_q <= 1'b1;
    end
endmodule

// File: rtl/region_decode.sv
module region_decode
    import bootmap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 20,
    parameter logic [NUM_TGT-1:0][ADDR_W-1:0] BASES = '0
) (
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                strap,
    input  logic                remapped,
    output logic [NUM_TGT-1:0]  sel,
    output logic [WIN_BITS-1:0] offset,
    output logic                err
);
    localparam int PAGE_W = ADDR_W - WIN_BITS;

    logic [PAGE_W-1:0] page;
    logic              in_alias;
    tgt_e              alias_tgt;

    assign page      = acc_addr[ADDR_W-1:WIN_BITS];
    assign in_alias  = (page == '0);
    assign alias_tgt = alias_route(strap, remapped);

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
        logic fixed_hit;
        logic alias_hit;
        assign fixed_hit = (page == BASES[i][ADDR_W-1:WIN_BITS]);
        assign alias_hit = in_alias && (int'(alias_tgt) == i);
        assign sel[i]    = acc_valid && (fixed_hit || alias_hit);
    end

    assign err    = acc_valid && (sel == '0);
    assign offset = acc_addr[WIN_BITS-1:0];
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 20,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0040_0000,
    parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] BANKC_BASE = 32'h0030_0000,
    parameter logic [ADDR_W-1:0] BANKA_BASE = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] BANKB_BASE = 32'h0020_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                boot_mode_pin,
    input  logic                cfg_wr,
    input  logic                cfg_wdata,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic [NUM_TGT-1:0]  tgt_sel,
    output logic [WIN_BITS-1:0] tgt_offset,
    output logic                dec_err
);
    localparam logic [NUM_TGT-1:0][ADDR_W-1:0] BASE_TAB =
        {BANKB_BASE, BANKA_BASE, BANKC_BASE, EXT_BASE, ROM_BASE};

    logic strap_q;
    logic remap_q;

    boot_strap_latch u_strap (
        .clk     (clk),
        .rst     (rst),
        .pin     (boot_mode_pin),
        .strap_q (strap_q)
    );

    remap_ctrl u_remap (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .wbit    (cfg_wdata),
        .remap_q (remap_q)
    );

    region_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .BASES    (BASE_TAB)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .strap     (strap_q),
        .remapped  (remap_q),
        .sel       (tgt_sel),
        .offset    (tgt_offset),
        .err       (dec_err)
    );
endmodule

// File: rtl/bootmap_checker.sv
module bootmap_checker #(
    parameter int PAGE_W  = 12,
    parameter int NUM_TGT = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_wr,
    input logic               cfg_wdata,
    input logic               acc_valid,
    input logic [PAGE_W-1:0]  acc_page,
    input logic               strap_q,
    input logic               remap_q,
    input logic [NUM_TGT-1:0] tgt_sel,
    input logic               dec_err
);
    logic in_win;
    assign in_win = acc_valid && (acc_page == '0);

    assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(strap_q));

    assert_rom_alias_R2: assert property (@(posedge clk) disable iff (rst)
        (in_win && !remap_q && strap_q) |-> (tgt_sel == 5'b00001));

    assert_ext_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (in_win && !remap_q && !strap_q) |-> (tgt_sel == 5'b00010));

    assert_remap_set_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wdata) |=> remap_q);

    assert_remap_alias_R4: assert property (@(posedge clk) disable iff (rst)
        (in_win && remap_q) |-> (tgt_sel == 5'b00100));

    assert_remap_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        remap_q |=> remap_q);

    assert_err_no_sel_R8: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (tgt_sel == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (tgt_sel == '0 && !dec_err));

    assert_onehot_sel_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_sel));
endmodule

bind bootmap_decoder bootmap_checker #(
    .PAGE_W  (ADDR_W - WIN_BITS),
    .NUM_TGT (bootmap_pkg::NUM_TGT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .acc_valid (acc_valid),
    .acc_page  (acc_addr[ADDR_W-1:WIN_BITS]),
    .strap_q   (strap_q),
    .remap_q   (remap_q),
    .tgt_sel   (tgt_sel),
    .dec_err   (dec_err)
);

// File: tb/sim_bootmap_decoder.sv
module sim_bootmap_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_mode_pin = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_wdata = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [4:0]  tgt_sel;
    logic [19:0] tgt_offset;
    logic        dec_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    bootmap_decoder u0 (
        .clk           (clk),
        .rst           (rst),
        .boot_mode_pin (boot_mode_pin),
        .cfg_wr        (cfg_wr),
        .cfg_wdata     (cfg_wdata),
        .acc_valid     (acc_valid),
        .acc_addr      (acc_addr),
        .tgt_sel       (tgt_sel),
        .tgt_offset    (tgt_offset),
        .dec_err       (dec_err)
    );

    localparam logic [4:0] S_ROM = 5'b00001, S_EXT = 5'b00010, S_C = 5'b00100,
                           S_A = 5'b01000, S_B = 5'b10000, S_NONE = 5'b00000;

    // {address, expected select, expected error}; strap 1, no remap.
    // R2, R6, R7 and R8 cases.
    localparam int NV = 12;
    localparam logic [37:0] VEC [NV] = '{
        {32'h0000_1234, S_ROM,  1'b0},
        {32'h000F_FFFF, S_ROM,  1'b0},
        {32'h0010_0000, S_A,    1'b0},
        {32'h001A_BCDE, S_A,    1'b0},
        {32'h0020_0010, S_B,    1'b0},
        {32'h0030_0004, S_C,    1'b0},
        {32'h003F_FFFC, S_C,    1'b0},
        {32'h0040_0000, S_ROM,  1'b0},
        {32'h1000_0100, S_EXT,  1'b0},
        {32'h0050_0000, S_NONE, 1'b1},
        {32'h0FFF_FFFF, S_NONE, 1'b1},
        {32'hFFFF_FFFF, S_NONE, 1'b1}
    };

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1;
        boot_mode_pin = pin;
        acc_valid = 1'b0;
        cfg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic probe(input logic v, input logic [31:0] a,
                         input logic [4:0] es, input logic ee, input string tag);
        @(negedge clk);
        acc_valid = v;
        acc_addr  = a;
        #2;
        n_chk++;
        if (tgt_sel !== es || dec_err !== ee ||
            (v && tgt_offset !== a[19:0])) begin
            n_bad++;
            $display("FAIL %s addr=%h sel=%b err=%b off=%h expected sel=%b err=%b off=%h",
                     tag, a, tgt_sel, dec_err, tgt_offset, es, ee, a[19:0]);
        end
    endtask

    task automatic cfg_write(input logic b);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = b;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // R9: reset state, no valid access
        probe(1'b0, 32'h0000_0000, S_NONE, 1'b0, "R9 idle after reset");

        for (int i = 0; i < NV; i++)
            probe(1'b1, VEC[i][37:6], VEC[i][5:1], VEC[i][0], "R2/R6/R7/R8 table");

        // R1: pin changes after reset are ignored
        @(negedge clk) boot_mode_pin = 1'b0;
        repeat (3) @(negedge clk);
        probe(1'b1, 32'h0000_0040, S_ROM, 1'b0, "R1 pin change ignored");

        // R5: a write of 0 does not remap
        cfg_write(1'b0);
        probe(1'b1, 32'h0000_0040, S_ROM, 1'b0, "R5 zero write no remap");

        // R4: write cycle keeps old routing, next cycle goes to remap bank
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = 1'b1;
        acc_valid = 1'b1;
        acc_addr = 32'h0000_0008;
        #2;
        n_chk++;
        if (tgt_sel !== S_ROM) begin
            n_bad++;
            $display("FAIL R4 write cycle sel=%b expected %b", tgt_sel, S_ROM);
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        #2;
        n_chk++;
        if (tgt_sel !== S_C || tgt_offset !== 20'h00008) begin
            n_bad++;
            $display("FAIL R4 after write sel=%b off=%h expected %b %h",
                     tgt_sel, tgt_offset, S_C, 20'h00008);
        end

        // R6: fixed bases still reachable after remap
        probe(1'b1, 32'h0040_0100, S_ROM, 1'b0, "R6 rom base after remap");
        probe(1'b1, 32'h0030_0100, S_C,   1'b0, "R6 bank C base after remap");
        probe(1'b1, 32'h0000_0100, S_C,   1'b0, "R7 alias offset after remap");

        // R5: sticky across zero write and pin toggling
        cfg_write(1'b0);
        @(negedge clk) boot_mode_pin = 1'b1;
        probe(1'b1, 32'h000F_FFF0, S_C, 1'b0, "R5 remap sticky");

        // R3 and R5: reset with strap 0 clears remap, alias to external
        do_reset(1'b0);
        probe(1'b1, 32'h0000_2000, S_EXT, 1'b0, "R3 ext alias / R5 cleared");
        @(negedge clk) boot_mode_pin = 1'b1;
        probe(1'b1, 32'h0000_2000, S_EXT, 1'b0, "R1 pin ignored strap 0");
        probe(1'b1, 32'h1000_2000, S_EXT, 1'b0, "R6 ext base");

        // R4: remap overrides strap 0
        cfg_write(1'b1);
        probe(1'b1, 32'h0000_2000, S_C, 1'b0, "R4 remap over strap 0");

        // R9 with an alias address, R10 implied by exact compares
        probe(1'b0, 32'h0000_2000, S_NONE, 1'b0, "R9 idle alias addr");
        probe(1'b1, 32'h0060_0000, S_NONE, 1'b1, "R8 unmapped after remap");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule